// File: doc/BRIEF.md
# SPI Master with Collision and Mode-Fault Detection

This block is a byte-wide SPI master driven through a four-address register port of the kind a small microcontroller presents. A write to the data address loads a byte and starts a transfer. The byte leaves on MOSI, most significant bit first. At the same time eight bits are gathered from MISO. When the eighth bit is in, the received byte can be read back from the same address. A control register sets the serial clock idle level, the sampling phase and a power-of-two bit-rate divider. A separate register names which of eight active-low slave selects go low while a byte is moving.

Two error detectors guard the shared bus. A data write that arrives while a byte is still moving is dropped and raises a collision flag. If the shared select input is pulled low while this block is master, another master has taken the bus. The block then clears its own enable, releases its output enables, aborts any byte in flight and records a mode fault. Completion and both errors can drive one interrupt line.

Top module: `spi_fault_master`

## Requirements
- R1: Control bits 2:0 hold a rate code n. One SCK half period lasts 2^(n+1) system clocks, so the SCK period runs from clk/4 (n=0) to clk/512 (n=7). A byte takes 16 half periods from the start write.
- R2: Control bit 5 is the SCK idle level. While a byte moves, SCK toggles once per half period, and the first toggle comes one half period after the start.
- R3: Control bit 4 is the phase. With phase 0, MISO is sampled on each odd-numbered SCK toggle (1st, 3rd, ...) and MOSI changes on the even-numbered ones. With phase 1, MOSI changes on odd-numbered toggles after the first, and MISO is sampled on even-numbered toggles.
- R4: Addresses are 0 control, 1 status, 2 data, 3 select. A data write while enabled and idle starts a byte. The byte goes out MSB first while the incoming byte is gathered MSB first. A data read returns the last completed received byte.
- R5: Select output i is low only while a byte moves and bit i of the select register is 1. Otherwise all selects are high.
- R6: A data write while a byte moves sets status bit 6 (collision). The written value is dropped and the running byte is unaffected.
- R7: The shared select input low while control bit 6 (enable) is 1 sets status bit 5 (mode fault). It also clears the enable, drops the SCK, MOSI and select output enables, and aborts the byte.
- R8: Status bit 7 (done) sets when a byte completes. It clears only on a data read that follows a status read taken while done was set.
- R9: The collision and fault flags clear on a control write that follows a status read taken while either was set.
- R10: The three output enables follow control bit 6. Data writes while it is 0 are ignored, and after a fault it stays 0 until the control register is written again.
- R11: The rate, phase and idle level in effect for a byte are those present at its start write. Control writes during the byte take effect from the next byte.
- R12: The interrupt output is control bit 7 ANDed with the OR of done, collision and fault.
- R13: Status bit 0 reads 1 while a byte moves. After reset, every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives the clear sequences) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data out enable |
| miso_i | input | 1 | Serial data in |
| ss_o | output | NSS | Active-low slave selects |
| ss_oe | output | 1 | Slave select output enable |
| ss_n_i | input | 1 | Shared select sense; low means another master drives the bus |
| irq | output | 1 | Interrupt request |

## Verification
The sharpest overlap is a data write that lands on the very clock edge that completes a byte. That edge must set the done flag and the collision flag together, keep the completed received byte, and start nothing new. The bench aims this write by watching its own model's cycle count and strobing the write for the final cycle. It then compares the status bits, the interrupt and the data read against the model. A second overlap pairs a mode fault with a byte in flight: the abort must win over completion, and the bench checks that the enables drop and the flags clear only through the read-then-write sequence.

// File: rtl/spi_fault_master.sv
`timescale 1ns/1ps
module spi_fault_master #(
  parameter int NSS = 8,
  parameter int RW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     addr,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata,
  output logic           sck_o,
  output logic           sck_oe,
  output logic           mosi_o,
  output logic           mosi_oe,
  input  logic           miso_i,
  output logic [NSS-1:0] ss_o,
  output logic           ss_oe,
  input  logic           ss_n_i,
  output logic           irq
);
  localparam int HCW = (1 << RW) + 1;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2, A_SSEL = 2'd3;

  logic           irq_en, men, cpol, cpha;
  logic [RW-1:0]  rate;
  logic           cpol_l, cpha_l;
  logic [RW-1:0]  rate_l;
  logic           busy, phase;
  logic [HCW-1:0] hc;
  logic [3:0]     ec;
  logic [7:0]     txb, rxb, rxd;
  logic [NSS-1:0] ssel;
  logic           done, wcol, modf, arm_d, arm_e;

  wire [HCW-1:0] half_m1 = (HCW'(2) << rate_l) - HCW'(1);
  wire           tick    = busy && (hc == half_m1);
  wire           lead    = ~ec[0];
  wire           samp    = tick && (lead ^ cpha_l);
  wire           shft    = tick && !(lead ^ cpha_l) && (ec != 4'd0);
  wire [7:0]     rx_nxt  = {rxb[6:0], miso_i};
  wire           fault   = men && !ss_n_i;

  assign sck_o   = busy ? (cpol_l ^ phase) : cpol;
  assign mosi_o  = txb[7];
  assign sck_oe  = men;
  assign mosi_oe = men;
  assign ss_oe   = men;
  assign ss_o    = ~(ssel & {NSS{busy}});
  assign irq     = irq_en & (done | wcol | modf);

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {irq_en, men, cpol, cpha, 4'(rate)};
      A_STAT:  rdata = {done, wcol, modf, 4'b0, busy};
      A_DATA:  rdata = rxd;
      default: rdata = 8'(ssel);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {irq_en, men, cpol, cpha} <= '0;
      rate   <= '0;
      cpol_l <= 1'b0;
      cpha_l <= 1'b0;
      rate_l <= '0;
      busy   <= 1'b0;
      phase  <= 1'b0;
      hc     <= '0;
      ec     <= '0;
      txb    <= '0;
      rxb    <= '0;
      rxd    <= '0;
      ssel   <= '0;
      {done, wcol, modf, arm_d, arm_e} <= '0;
    end else begin
      if (rd_en && addr == A_STAT) begin
        arm_d <= done;
        arm_e <= wcol | modf;
      end
      if (rd_en && addr == A_DATA && arm_d) begin
        done  <= 1'b0;
        arm_d <= 1'b0;
      end
      if (wr_en) begin
        case (addr)
          A_CTRL: begin
            {irq_en, men, cpol, cpha} <= wdata[7:4];
            rate <= wdata[RW-1:0];
            if (arm_e) begin
              wcol  <= 1'b0;
              modf  <= 1'b0;
              arm_e <= 1'b0;
            end
          end
          A_SSEL: ssel <= wdata[NSS-1:0];
          A_DATA: begin
            if (busy) wcol <= 1'b1;
            else if (men) begin
              busy   <= 1'b1;
              hc     <= '0;
              ec     <= '0;
              phase  <= 1'b0;
              txb    <= wdata;
              rxb    <= '0;
              cpol_l <= cpol;
              cpha_l <= cpha;
              rate_l <= rate;
            end
          end
          default: ;
        endcase
      end
      if (tick) begin
        hc    <= '0;
        phase <= ~phase;
        ec    <= ec + 4'd1;
        if (samp) rxb <= rx_nxt;
        if (shft) txb <= {txb[6:0], 1'b0};
        if (ec == 4'd15) begin
          busy <= 1'b0;
          done <= 1'b1;
          rxd  <= samp ? rx_nxt : rxb;
        end
      end else if (busy) begin
        hc <= hc + HCW'(1);
      end
      if (fault) begin
        modf <= 1'b1;
        men  <= 1'b0;
        busy <= 1'b0;
      end
    end
  end

  // R6
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DATA && busy) |=> wcol);

  // R7
  modf_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (men && !ss_n_i) |=> (modf && !sck_oe && !mosi_oe && !ss_oe && !busy));

  // R8
  done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(men && !ss_n_i)) |-> done);

  // R10
  off_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DATA && !men && !busy) |=> !busy);

  // R11
  fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable({rate_l, cpol_l, cpha_l}));
endmodule

// File: tb/spi_fault_master_tb_top.sv
`timescale 1ns/1ps
module spi_fault_master_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic wr_en = 1'b0, rd_en = 1'b0, ss_n_in = 1'b1;
  logic [7:0] wdata = 8'h00, rdata;
  logic sck_o, sck_oe, mosi_o, mosi_oe, ss_oe, irq;
  logic [7:0] ss_o;
  logic miso_q = 1'b1;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  spi_fault_master dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_q), .ss_o(ss_o),
    .ss_oe(ss_oe), .ss_n_i(ss_n_in), .irq(irq));

  // reference model state
  int m_half = 2, m_cnt = 0;
  logic m_ie = 0, m_men = 0, m_cpol = 0, m_cpha = 0, m_cpol_l = 0, m_cpha_l = 0;
  logic [2:0] m_rate = 0;
  logic [7:0] m_ssc = 0, m_tx = 0, m_cap = 0, m_rxd = 0, sbyte = 0;
  logic m_busy = 0, m_done = 0, m_wcol = 0, m_modf = 0, m_ad = 0, m_ae = 0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rdata(input logic [1:0] a);
    case (a)
      2'd0: return {m_ie, m_men, m_cpol, m_cpha, 1'b0, m_rate};
      2'd1: return {m_done, m_wcol, m_modf, 4'b0, m_busy};
      2'd2: return m_rxd;
      default: return m_ssc;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic was_busy, men0, flt;
    int k, e, idx;
    if (!rst_n) begin
      m_half = 2; m_cnt = 0;
      {m_ie, m_men, m_cpol, m_cpha, m_cpol_l, m_cpha_l} = '0;
      m_rate = 0; m_ssc = 0; m_tx = 0; m_cap = 0; m_rxd = 0;
      {m_busy, m_done, m_wcol, m_modf, m_ad, m_ae} = '0;
      miso_q <= 1'b1;
    end else begin
      was_busy = m_busy;
      men0 = m_men;
      flt = men0 && !ss_n_in;
      if (rd_en && addr == 2'd1) begin m_ad = m_done; m_ae = m_wcol | m_modf; end
      if (rd_en && addr == 2'd2 && m_ad) begin m_done = 0; m_ad = 0; end
      if (wr_en) begin
        if (addr == 2'd0) begin
          {m_ie, m_men, m_cpol, m_cpha} = wdata[7:4];
          m_rate = wdata[2:0];
          if (m_ae) begin m_wcol = 0; m_modf = 0; m_ae = 0; end
        end else if (addr == 2'd3) m_ssc = wdata;
        else if (addr == 2'd2) begin
          if (was_busy) m_wcol = 1;
          else if (men0) begin
            m_busy = 1; m_cnt = 0; m_half = 2 << int'(m_rate);
            m_tx = wdata; m_cap = 0; m_cpol_l = m_cpol; m_cpha_l = m_cpha;
          end
        end
      end
      if (was_busy) begin
        if ((m_cnt + 1) % m_half == 0) begin
          k = m_cnt / m_half;
          if (((k % 2) == 1) == m_cpha_l) m_cap = {m_cap[6:0], mosi_o};
        end
        m_cnt++;
        if (m_cnt == 16 * m_half) begin
          m_busy = 0; m_done = 1; m_rxd = sbyte;
          check("R3 R4 mosi byte seen by slave", m_cap, m_tx);
        end
      end
      if (flt) begin m_modf = 1; m_men = 0; m_busy = 0; end
      if (m_busy) begin
        e = m_cnt / m_half;
        idx = m_cpha_l ? e / 2 : (e + 1) / 2;
        if (idx > 7) idx = 7;
        miso_q <= sbyte[7 - idx];
      end else miso_q <= sbyte[7];
    end
  end

  always @(negedge clk) begin : compare
    logic es;
    if (rst_n) begin
      es = m_busy ? (m_cpol_l ^ ((m_cnt / m_half) % 2 != 0)) : m_cpol;
      check("R1 R2 R11 sck", {7'b0, sck_o}, {7'b0, es});
      check("R5 selects", ss_o, m_busy ? ~m_ssc : 8'hFF);
      check("R7 R10 enables", {5'b0, sck_oe, mosi_oe, ss_oe}, {5'b0, {3{m_men}}});
      check("R12 irq", {7'b0, irq}, {7'b0, m_ie & (m_done | m_wcol | m_modf)});
      case (addr)
        2'd0: check("R10 R11 ctrl read", rdata, exp_rdata(addr));
        2'd1: check("R6 R7 R8 R9 R13 status read", rdata, exp_rdata(addr));
        2'd2: check("R3 R4 data read", rdata, exp_rdata(addr));
        default: check("R5 select read", rdata, exp_rdata(addr));
      endcase
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(posedge clk); #1;
    addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy) begin @(posedge clk); #1; end
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] sb);
    sbyte = sb;
    wr(2'd2, tx);
    wait_idle();
    rd(2'd1);
    rd(2'd2);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R13 reset values
    rd(2'd0); rd(2'd1); rd(2'd2); rd(2'd3);
    // R1..R5 all four formats, several rates
    wr(2'd3, 8'h05);
    wr(2'd0, 8'hC0);
    xfer(8'h3C, 8'hA5);
    wr(2'd0, 8'hD1);
    xfer(8'h81, 8'h7E);
    wr(2'd0, 8'hE2);
    xfer(8'hF0, 8'h0F);
    wr(2'd3, 8'h80);
    wr(2'd0, 8'hF3);
    xfer(8'h5A, 8'hC3);
    // R8 clear order: data read alone leaves done set
    wr(2'd0, 8'hC0);
    sbyte = 8'h99;
    wr(2'd2, 8'h11);
    wait_idle();
    rd(2'd2); rd(2'd1); rd(2'd2); rd(2'd1);
    // R6 R9 collision mid byte
    wr(2'd0, 8'hC1);
    sbyte = 8'h12;
    wr(2'd2, 8'h34);
    repeat (5) @(posedge clk);
    wr(2'd2, 8'hFF);
    wait_idle();
    rd(2'd1); rd(2'd2); wr(2'd0, 8'hC1); rd(2'd1);
    // R6 R8 collision on the completing edge
    wr(2'd0, 8'hD0);
    sbyte = 8'h44;
    wr(2'd2, 8'h22);
    while (!(m_busy && m_cnt == 16 * m_half - 1)) begin @(posedge clk); #1; end
    addr = 2'd2; wdata = 8'hEE; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
    rd(2'd1); rd(2'd2); wr(2'd0, 8'hC1); rd(2'd1);
    // R11 rate and format change mid byte
    wr(2'd0, 8'hC0);
    sbyte = 8'h3F;
    wr(2'd2, 8'hA0);
    repeat (3) @(posedge clk);
    wr(2'd0, 8'hF5);
    wait_idle();
    rd(2'd1); rd(2'd2);
    // R7 R10 mode fault during a byte
    wr(2'd0, 8'hC2);
    sbyte = 8'h55;
    wr(2'd2, 8'hAA);
    repeat (20) @(posedge clk);
    #1 ss_n_in = 1'b0;
    @(posedge clk);
    #1 ss_n_in = 1'b1;
    repeat (3) @(posedge clk);
    rd(2'd1);
    wr(2'd2, 8'h01);
    rd(2'd1); rd(2'd0);
    wr(2'd0, 8'hC2);
    rd(2'd1); rd(2'd0);
    xfer(8'h69, 8'h96);
    // R12 interrupt masked
    wr(2'd0, 8'h40);
    sbyte = 8'h00;
    wr(2'd2, 8'h0F);
    wr(2'd2, 8'h0F);
    wait_idle();
    rd(2'd1); rd(2'd2); wr(2'd0, 8'h40); rd(2'd1);
    // R1 slowest rate
    wr(2'd3, 8'hFF);
    wr(2'd0, 8'h47);
    xfer(8'hC6, 8'h6C);
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule